// File: doc/BRIEF.md
# Two-Bank SDRAM Command Protocol Monitor

This block sits beside the command pins of a two-bank synchronous DRAM and observes them on every rising clock edge. It turns the pin pattern into a command, keeps a model of which bank has an open row, and tracks three timing conditions. The first is the quiet window after a mode-register load. The second is the burst length chosen by that load. The third is whether a read or write with automatic precharge is still bursting. When a command arrives in a state that forbids it, the monitor raises a violation flag for one cycle and gives an error code.

The monitor is passive. It drives nothing towards the memory. Its outputs are the decoded command, the violation flag with its code, a per-bank open-row vector and a self-refresh indication. All outputs are registered: a command sampled at edge k appears on the outputs after edge k. The internal state is that of a correct memory. A flagged command is treated as if it had never been issued.

Top module: `sdr_cmd_monitor`

## Requirements
- R1: A command sampled at edge k is reported on `cmd_o` after edge k. The code comes from the previous-cycle clock enable, `cs_n`, and {ras_n,cas_n,we_n}. If the clock enable at the previous edge was low, the code is 10 (suspended). Otherwise `cs_n` high gives 0 (deselect). With `cs_n` low, the pin pattern selects the command:
  - 000 gives 2 (mode set).
  - 001 gives 3 (auto refresh) when `cke` is high, and 4 (self-refresh entry) when `cke` is low.
  - 011 gives 5 (activate).
  - 101 gives 6 (read).
  - 100 gives 7 (write).
  - 110 gives 8 (burst stop).
  - 010 gives 9 (precharge).
  - 111 gives 1 (no operation).
- R2: While reset is held and after it is released, the outputs start as follows until the first command is reported: `cmd_o` is 0, `viol_o` is 0, `err_o` is 0, `bank_open_o` is 0 and `sref_o` is 0. The first edge after reset release reports code 10.
- R3: A mode set while either bank is open is flagged with code 1.
- R4: A mode set that is not flagged loads the burst-length field from `addr[2:0]`. Any command other than 0, 1 or 10 on the next two edges is flagged with code 2. Code 2 takes priority over every other code.
- R5: An auto refresh or self-refresh entry while either bank is open is flagged with code 3.
- R6: An activate to an idle bank sets bit `ba` of `bank_open_o` (bank A is bit 0, bank B is bit 1). An activate to an open bank is flagged with code 4.
- R7: A read or write to an idle bank is flagged with code 5.
- R8: A precharge with `addr[10]` high closes both banks and ignores `ba`. With `addr[10]` low, it closes only bank `ba`. A precharge to an idle bank is legal.
- R9: The burst length N is set by the mode field: 0 gives 1, 1 gives 2, 2 gives 4, and 3 to 7 give 8. After reset N is 1. A read or write at edge k with `addr[10]` high starts an automatic-precharge burst. Its bank reads idle from edge k+N-1 onward, so with N=1 it is idle right after edge k. Any read or write sampled on edges k+1 to k+N-1 is flagged with code 6, which takes priority over code 5.
- R10: A burst stop during an automatic-precharge burst ends the burst and closes that bank at once. With no such burst it changes nothing.
- R11: An unflagged self-refresh entry sets `sref_o`. Every following edge reports code 10 while `cke` stays low. `sref_o` clears at the edge where `cke` returns high.
- R12: `viol_o` is high, with a nonzero `err_o`, for exactly the reporting cycle of each offending command. A flagged command changes no bank, mode, burst or self-refresh state.
- R13: An edge whose previous-cycle clock enable was low does not advance an automatic-precharge burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; pins sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 1 | Bank select |
| addr | input | 11 | Address pins; bit 10 is the auto-precharge / all-banks flag, bits 2..0 the burst field on a mode set |
| cmd_o | output | 4 | Decoded command code (R1) |
| viol_o | output | 1 | One-cycle violation flag |
| err_o | output | 3 | Violation code, 0 when none |
| bank_open_o | output | 2 | Open-row flag per bank |
| sref_o | output | 1 | Self refresh in progress |

## Verification
The assertions assume that reset is driven low from time zero. They also assume that the pins carry known values at every rising edge, so that each observed command is a real command. The bench changes every input only on the falling clock edge and holds reset for several cycles before releasing it. After release it lets the synchronizer settle before issuing commands. The stimulus sweeps every pin pattern, with both clock-enable levels, both banks and both levels of the precharge flag, from each of the four bank states. Directed runs cover burst lengths 1 to 16 (the last mapping to 8), clock suspension in mid-burst, burst stop and self refresh.

// File: rtl/sdr_mon_pkg.sv
package sdr_mon_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_MRS   = 4'd2,
    CMD_REF   = 4'd3,
    CMD_SREF  = 4'd4,
    CMD_ACT   = 4'd5,
    CMD_RD    = 4'd6,
    CMD_WR    = 4'd7,
    CMD_BST   = 4'd8,
    CMD_PRE   = 4'd9,
    CMD_SUSP  = 4'd10
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_MRS_BUSY = 3'd1,
    ERR_MRS_REC  = 3'd2,
    ERR_REF_BUSY = 3'd3,
    ERR_ACT_OPEN = 3'd4,
    ERR_RW_IDLE  = 3'd5,
    ERR_RW_AP    = 3'd6
  } err_e;

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_mon_pkg::*;
(
  input  logic cke_prev,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (!cke_prev) begin
      cmd = CMD_SUSP;
    end else if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = cke ? CMD_REF : CMD_SREF;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = CMD_PRE;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdr_bank_flag.sv
module sdr_bank_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic open_o
);

  logic open_q;
  logic open_d;
  logic open_en;

  always_comb begin
    open_en = set_i | clr_i;
    open_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else if (open_en) begin
      open_q <= open_d;
    end
  end

  assign open_o = open_q;

  // R6 R8: an opening and a closing request never target one bank together
  a_r6_no_set_clr_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_i && clr_i));

endmodule

// File: rtl/sdr_seq_track.sv
module sdr_seq_track #(
  parameter int BA_W        = 1,
  parameter int MODE_W      = 3,
  parameter int MAX_BL_LOG2 = 3,
  parameter int REC_CYC     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_load,
  input  logic [MODE_W-1:0] mode_code,
  input  logic              clk_run,
  input  logic              ap_start,
  input  logic [BA_W-1:0]   ap_bank_i,
  input  logic              ap_kill,
  output logic              rec_busy,
  output logic              bl_one,
  output logic              ap_busy,
  output logic [BA_W-1:0]   ap_bank_o,
  output logic              ap_done
);

  localparam int CNT_W = MAX_BL_LOG2;
  localparam int REC_W = $clog2(REC_CYC + 1);

  logic [MODE_W-1:0] mode_q;
  logic [REC_W-1:0]  rec_q, rec_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, bl_m1;
  logic [CNT_W:0]    bl_full;
  logic              busy_q, busy_d;
  logic [BA_W-1:0]   bank_q, bank_d;
  logic              ap_en;

  // burst length from the stored mode field, saturating at the largest size
  always_comb begin
    if (int'(mode_q) > MAX_BL_LOG2) begin
      bl_full = (CNT_W + 1)'(1) << MAX_BL_LOG2;
    end else begin
      bl_full = (CNT_W + 1)'(1) << mode_q;
    end
    bl_m1  = CNT_W'(bl_full - 1'b1);
    bl_one = (bl_full == (CNT_W + 1)'(1));
  end

  assign ap_done = busy_q && clk_run && (cnt_q == CNT_W'(1));

  always_comb begin
    rec_d = rec_q;
    if (mrs_load) begin
      rec_d = REC_W'(REC_CYC);
    end else if (rec_q != '0) begin
      rec_d = rec_q - 1'b1;
    end

    busy_d = busy_q;
    cnt_d  = cnt_q;
    bank_d = bank_q;
    if (ap_start && !bl_one) begin
      busy_d = 1'b1;
      cnt_d  = bl_m1;
      bank_d = ap_bank_i;
    end else if (ap_kill) begin
      busy_d = 1'b0;
    end else if (busy_q && clk_run) begin
      if (ap_done) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    ap_en = (ap_start && !bl_one) || ap_kill || (busy_q && clk_run);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rec_q  <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      bank_q <= '0;
    end else begin
      if (mrs_load) begin
        mode_q <= mode_code;
      end
      rec_q <= rec_d;
      if (ap_en) begin
        busy_q <= busy_d;
        cnt_q  <= cnt_d;
        bank_q <= bank_d;
      end
    end
  end

  assign rec_busy  = (rec_q != '0);
  assign ap_busy   = busy_q;
  assign ap_bank_o = bank_q;

  // R4: a mode load is never accepted inside the quiet window
  a_r4_no_load_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_load |-> !rec_busy);

  // R9: no second automatic-precharge burst starts while one runs
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ap_start |-> !ap_busy);

  // R9: a running burst always has beats left
  a_r9_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    ap_busy |-> (cnt_q != '0));

endmodule

// File: rtl/sdr_cmd_monitor.sv
module sdr_cmd_monitor
  import sdr_mon_pkg::*;
#(
  parameter  int NUM_BANKS   = 2,
  parameter  int AP_BIT      = 10,
  parameter  int MODE_W      = 3,
  parameter  int MAX_BL_LOG2 = 3,
  parameter  int REC_CYC     = 2,
  localparam int BA_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W      = AP_BIT + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic [3:0]           cmd_o,
  output logic                 viol_o,
  output logic [2:0]           err_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic                 sref_o
);

  // reset: asserted at once, released after two edges
  logic [1:0] rst_pipe;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_i_n = rst_pipe[1];

  logic                 cke_prev_q;
  cmd_e                 cmd_d, cmd_q;
  err_e                 err_d, err_q;
  logic                 viol_q;
  logic                 sref_q, sref_d, sref_en;
  logic [NUM_BANKS-1:0] bank_q, bank_set, bank_clr;
  logic                 ok, is_rw, ap_flag, sel_open, all_idle;
  logic                 rec_busy, bl_one, ap_busy, ap_done;
  logic [BA_W-1:0]      ap_bank;
  logic                 mrs_load, ap_start, ap_kill;
  logic                 unused_addr;

  assign unused_addr = ^addr[AP_BIT-1:MODE_W];

  sdr_cmd_decode u_dec (
    .cke_prev (cke_prev_q),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .cmd      (cmd_d)
  );

  sdr_seq_track #(
    .BA_W        (BA_W),
    .MODE_W      (MODE_W),
    .MAX_BL_LOG2 (MAX_BL_LOG2),
    .REC_CYC     (REC_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .mrs_load  (mrs_load),
    .mode_code (addr[MODE_W-1:0]),
    .clk_run   (cke_prev_q),
    .ap_start  (ap_start),
    .ap_bank_i (ba),
    .ap_kill   (ap_kill),
    .rec_busy  (rec_busy),
    .bl_one    (bl_one),
    .ap_busy   (ap_busy),
    .ap_bank_o (ap_bank),
    .ap_done   (ap_done)
  );

  // legality of the sampled command against the tracked state
  always_comb begin
    ap_flag  = addr[AP_BIT];
    is_rw    = (cmd_d == CMD_RD) || (cmd_d == CMD_WR);
    sel_open = bank_q[ba];
    all_idle = (bank_q == '0);
    err_d    = ERR_NONE;
    if (rec_busy && !(cmd_d inside {CMD_NOP, CMD_DESEL, CMD_SUSP})) begin
      err_d = ERR_MRS_REC;
    end else begin
      unique case (cmd_d)
        CMD_MRS:          if (!all_idle) err_d = ERR_MRS_BUSY;
        CMD_REF,
        CMD_SREF:         if (!all_idle) err_d = ERR_REF_BUSY;
        CMD_ACT:          if (sel_open)  err_d = ERR_ACT_OPEN;
        CMD_RD,
        CMD_WR: begin
          if (ap_busy)        err_d = ERR_RW_AP;
          else if (!sel_open) err_d = ERR_RW_IDLE;
        end
        default: err_d = ERR_NONE;
      endcase
    end
    ok       = (err_d == ERR_NONE);
    mrs_load = ok && (cmd_d == CMD_MRS);
    ap_start = ok && is_rw && ap_flag;
    ap_kill  = ok && ((cmd_d == CMD_BST) ||
                      ((cmd_d == CMD_PRE) && (ap_flag || (ba == ap_bank))));
  end

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    logic hit;
    logic ap_hit;
    assign hit    = (ba == BA_W'(gi));
    assign ap_hit = (ap_bank == BA_W'(gi));
    assign bank_set[gi] = ok && (cmd_d == CMD_ACT) && hit;
    assign bank_clr[gi] = (ok && (cmd_d == CMD_PRE) && (ap_flag || hit)) ||
                          (ap_done && ap_hit) ||
                          (ok && (cmd_d == CMD_BST) && ap_busy && ap_hit) ||
                          (ok && is_rw && ap_flag && bl_one && hit);

    sdr_bank_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .set_i  (bank_set[gi]),
      .clr_i  (bank_clr[gi]),
      .open_o (bank_q[gi])
    );
  end

  always_comb begin
    sref_en = (ok && (cmd_d == CMD_SREF)) || (sref_q && !cke_prev_q && cke);
    sref_d  = ok && (cmd_d == CMD_SREF);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cke_prev_q <= 1'b0;
      cmd_q      <= CMD_DESEL;
      err_q      <= ERR_NONE;
      viol_q     <= 1'b0;
      sref_q     <= 1'b0;
    end else begin
      cke_prev_q <= cke;
      cmd_q      <= cmd_d;
      err_q      <= err_d;
      viol_q     <= !ok;
      if (sref_en) begin
        sref_q <= sref_d;
      end
    end
  end

  assign cmd_o       = cmd_q;
  assign err_o       = err_q;
  assign viol_o      = viol_q;
  assign bank_open_o = bank_q;
  assign sref_o      = sref_q;

  // R3: an accepted mode set found both banks idle
  a_r3_mrs_idle: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_q == CMD_MRS && !viol_q) |-> ($past(bank_q) == '0));

  // R5: an accepted refresh of either kind found both banks idle
  a_r5_ref_idle: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((cmd_q == CMD_REF || cmd_q == CMD_SREF) && !viol_q) |-> ($past(bank_q) == '0));

  // R7: an accepted read or write found some row open
  a_r7_rw_open: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((cmd_q == CMD_RD || cmd_q == CMD_WR) && !viol_q) |-> ($past(bank_q) != '0));

  // R4: the edge after an accepted mode set is quiet or flagged as such
  a_r4_quiet_after_mrs: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_q == CMD_MRS && !viol_q) |=>
      ((cmd_q inside {CMD_NOP, CMD_DESEL, CMD_SUSP}) || (err_q == ERR_MRS_REC)));

  // R11: while self refresh persists, every edge is a suspended one
  a_r11_sref_suspended: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sref_q && $past(sref_q)) |-> (cmd_q == CMD_SUSP));

  // R12: the flag and the code agree
  a_r12_flag_code: assert property (@(posedge clk) disable iff (!rst_i_n)
    viol_q |-> (err_q != ERR_NONE));

endmodule

// File: tb/sdr_cmd_monitor_test.sv
`timescale 1ns/1ps
module sdr_cmd_monitor_test;

  localparam logic [2:0] OP_MRS = 3'b000;
  localparam logic [2:0] OP_REF = 3'b001;
  localparam logic [2:0] OP_ACT = 3'b011;
  localparam logic [2:0] OP_RD  = 3'b101;
  localparam logic [2:0] OP_WR  = 3'b100;
  localparam logic [2:0] OP_BST = 3'b110;
  localparam logic [2:0] OP_PRE = 3'b010;
  localparam logic [2:0] OP_NOP = 3'b111;

  logic        clk = 1'b0;
  logic        rst_n, cke, cs_n, ras_n, cas_n, we_n;
  logic [0:0]  ba;
  logic [10:0] addr;
  logic [3:0]  cmd_o;
  logic        viol_o;
  logic [2:0]  err_o;
  logic [1:0]  bank_open_o;
  logic        sref_o;

  int vectors = 0;
  int fails   = 0;

  // expected state built from the requirements
  logic [1:0] m_open;
  int         m_bl, m_rec, m_apc;
  logic       m_apb, m_apbank, m_sref, m_ckep;

  always #2.5 clk = ~clk;

  sdr_cmd_monitor uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o),
    .viol_o(viol_o), .err_o(err_o), .bank_open_o(bank_open_o), .sref_o(sref_o)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  // called on a falling edge; returns on the next falling edge
  task automatic apply(input logic k, input logic [2:0] op, input logic c,
                       input logic b, input logic [10:0] a, input string tag);
    int ec, ee;
    logic [1:0] nopen;
    logic nb, sel, bad;
    sel = m_open[b];
    if (!m_ckep) ec = 10;
    else if (c) ec = 0;
    else begin
      case (op)
        OP_MRS:  ec = 2;
        OP_REF:  ec = k ? 3 : 4;
        OP_ACT:  ec = 5;
        OP_RD:   ec = 6;
        OP_WR:   ec = 7;
        OP_BST:  ec = 8;
        OP_PRE:  ec = 9;
        default: ec = 1;
      endcase
    end
    ee = 0;
    if (m_rec > 0 && !(ec == 0 || ec == 1 || ec == 10)) ee = 2;          // R4
    else if (ec == 2 && m_open != 0) ee = 1;                              // R3
    else if ((ec == 3 || ec == 4) && m_open != 0) ee = 3;                 // R5
    else if (ec == 5 && sel) ee = 4;                                      // R6
    else if ((ec == 6 || ec == 7) && m_apb) ee = 6;                       // R9
    else if ((ec == 6 || ec == 7) && !sel) ee = 5;                        // R7
    nopen = m_open;
    nb = m_apb;
    if (m_apb && m_ckep) begin                                            // R13
      if (m_apc == 1) begin nb = 1'b0; nopen[m_apbank] = 1'b0; end
      else m_apc = m_apc - 1;
    end
    if (ee == 0) begin                                                    // R12
      case (ec)
        2: m_bl = (a[2:0] > 3) ? 8 : (1 << a[2:0]);
        4: m_sref = 1'b1;
        5: nopen[b] = 1'b1;
        6, 7: if (a[10]) begin
          if (m_bl == 1) nopen[b] = 1'b0;
          else begin nb = 1'b1; m_apc = m_bl - 1; m_apbank = b; end
        end
        8: if (m_apb) begin nopen[m_apbank] = 1'b0; nb = 1'b0; end     // R10
        9: begin                                                          // R8
          if (a[10]) nopen = 2'b00; else nopen[b] = 1'b0;
          if (a[10] || b == m_apbank) nb = 1'b0;
        end
        default: ;
      endcase
    end
    if (m_sref && !m_ckep && k) m_sref = 1'b0;                            // R11
    m_rec  = (ee == 0 && ec == 2) ? 2 : ((m_rec > 0) ? m_rec - 1 : 0);
    m_apb  = nb;
    m_open = nopen;
    m_ckep = k;

    cke = k; cs_n = c; {ras_n, cas_n, we_n} = op; ba = b; addr = a;
    @(posedge clk);
    @(negedge clk);
    vectors++;
    bad = 1'b0;
    if (cmd_o != 4'(ec)) begin
      bad = 1'b1;
      $display("FAIL R1 [%s] cmd_o=%0d expected %0d", tag, cmd_o, ec);
    end
    if (err_o != 3'(ee) || viol_o != (ee != 0)) begin
      bad = 1'b1;
      $display("FAIL R12 [%s] err_o=%0d viol_o=%0b expected %0d %0b",
               tag, err_o, viol_o, ee, ee != 0);
    end
    if (bank_open_o != m_open) begin
      bad = 1'b1;
      $display("FAIL R6 [%s] bank_open_o=%b expected %b", tag, bank_open_o, m_open);
    end
    if (sref_o != m_sref) begin
      bad = 1'b1;
      $display("FAIL R11 [%s] sref_o=%b expected %b", tag, sref_o, m_sref);
    end
    if (bad) fails++;
  endtask

  task automatic nop(input string tag);
    apply(1'b1, OP_NOP, 1'b0, 1'b0, 11'd0, tag);
  endtask

  task automatic clean(input logic [1:0] s);
    nop("R1 prep"); nop("R1 prep"); nop("R1 prep");
    apply(1'b1, OP_PRE, 1'b0, 1'b0, 11'h400, "R8 prep");
    if (s[0]) apply(1'b1, OP_ACT, 1'b0, 1'b0, 11'd0, "R6 prep");
    if (s[1]) apply(1'b1, OP_ACT, 1'b0, 1'b1, 11'd0, "R6 prep");
  endtask

  task automatic set_bl(input logic [2:0] code);
    clean(2'b00);
    apply(1'b1, OP_MRS, 1'b0, 1'b0, {8'd0, code}, "R4 mode");
    nop("R4 quiet"); nop("R4 quiet");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b0; {ras_n, cas_n, we_n} = OP_NOP;
    ba = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    // R2: state while reset is held
    vectors++;
    if (cmd_o != 4'd0 || viol_o || err_o != 3'd0 || bank_open_o != 2'b00 || sref_o) begin
      fails++;
      $display("FAIL R2 reset cmd=%0d viol=%b err=%0d open=%b sref=%b expected 0 0 0 00 0",
               cmd_o, viol_o, err_o, bank_open_o, sref_o);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2: still at reset values until the first functional edge
    vectors++;
    if (cmd_o != 4'd0 || bank_open_o != 2'b00) begin
      fails++;
      $display("FAIL R2 release cmd=%0d open=%b expected 0 00", cmd_o, bank_open_o);
    end
    m_open = 2'b00; m_bl = 1; m_rec = 0; m_apc = 0; m_apb = 1'b0;
    m_apbank = 1'b0; m_sref = 1'b0; m_ckep = 1'b0;
    nop("R2 first edge reports suspended");

    // sweep: every pin pattern x cke x bank x flag from every bank state
    for (int s = 0; s < 4; s++)
      for (int op = 0; op < 8; op++)
        for (int k = 0; k < 2; k++)
          for (int b = 0; b < 2; b++)
            for (int f = 0; f < 2; f++) begin
              clean(2'(s));
              apply(1'(k), 3'(op), 1'b0, 1'(b), {1'(f), 7'd0, 3'(s + b)},
                    "R1 R3 R5 R6 R7 R8 sweep");
              nop("R4 R11 after");
            end
    clean(2'b00);
    apply(1'b1, OP_NOP, 1'b1, 1'b1, 11'h7ff, "R1 deselect");

    // R9 / R4: each burst length, with reads and writes attempted mid-burst
    for (int code = 0; code < 5; code++)
      for (int w = 0; w < 2; w++) begin
        clean(2'b00);
        apply(1'b1, OP_MRS, 1'b0, 1'b0, 11'(code), "R4 mode");
        apply(1'b1, OP_ACT, 1'b0, 1'b0, 11'd0, "R4 act in window");
        nop("R4 quiet");
        apply(1'b1, OP_ACT, 1'b0, 1'b0, 11'd0, "R6 act");
        apply(1'b1, OP_ACT, 1'b0, 1'b1, 11'd0, "R6 act");
        apply(1'b1, w ? OP_WR : OP_RD, 1'b0, 1'b0, 11'h400, "R9 ap start");
        apply(1'b1, OP_RD, 1'b0, 1'b1, 11'd0, "R9 rw during burst");
        for (int j = 0; j < 9; j++)
          apply(1'b1, (j % 2) ? OP_WR : OP_NOP, 1'b0, 1'b1, 11'd0, "R9 burst tail");
      end

    // R10: burst stop ends the burst and closes the bank
    set_bl(3'd3);
    apply(1'b1, OP_BST, 1'b0, 1'b0, 11'd0, "R10 idle stop");
    apply(1'b1, OP_ACT, 1'b0, 1'b1, 11'd0, "R10 act");
    apply(1'b1, OP_RD, 1'b0, 1'b1, 11'h400, "R10 ap read");
    nop("R10 burst");
    apply(1'b1, OP_BST, 1'b0, 1'b0, 11'd0, "R10 stop");
    apply(1'b1, OP_RD, 1'b0, 1'b1, 11'd0, "R10 bank idle");

    // R13: suspension freezes the burst
    set_bl(3'd2);
    apply(1'b1, OP_ACT, 1'b0, 1'b0, 11'd0, "R13 act");
    apply(1'b0, OP_WR, 1'b0, 1'b0, 11'h400, "R13 ap write");
    for (int j = 0; j < 4; j++) apply(1'b0, OP_NOP, 1'b0, 1'b0, 11'd0, "R13 suspended");
    for (int j = 0; j < 5; j++) apply(1'b1, OP_NOP, 1'b0, 1'b0, 11'd0, "R13 resumed");

    // R11 / R5: self refresh entry, hold, exit; refused with a row open
    clean(2'b00);
    apply(1'b0, OP_REF, 1'b0, 1'b0, 11'd0, "R11 entry");
    for (int j = 0; j < 3; j++) apply(1'b0, OP_ACT, 1'b0, 1'b0, 11'd0, "R11 held");
    apply(1'b1, OP_NOP, 1'b0, 1'b0, 11'd0, "R11 exit");
    nop("R11 after");
    clean(2'b10);
    apply(1'b0, OP_REF, 1'b0, 1'b0, 11'd0, "R5 R11 refused entry");
    apply(1'b1, OP_NOP, 1'b0, 1'b0, 11'd0, "R11 power down exit");

    // R12 / R8: repeated violations keep state; precharge variants
    clean(2'b01);
    for (int j = 0; j < 3; j++) apply(1'b1, OP_ACT, 1'b0, 1'b0, 11'd0, "R12 repeat");
    apply(1'b1, OP_RD, 1'b0, 1'b1, 11'd0, "R12 idle read");
    apply(1'b1, OP_MRS, 1'b0, 1'b0, 11'd3, "R3 R12 mode open");
    apply(1'b1, OP_ACT, 1'b0, 1'b1, 11'd0, "R8 act");
    apply(1'b1, OP_PRE, 1'b0, 1'b0, 11'd0, "R8 single");
    apply(1'b1, OP_PRE, 1'b0, 1'b0, 11'd0, "R8 idle pre");
    apply(1'b1, OP_ACT, 1'b0, 1'b0, 11'd0, "R8 act");
    apply(1'b1, OP_PRE, 1'b0, 1'b0, 11'h400, "R8 all");

    summary();
    $finish;
  end

endmodule